// File: doc/BRIEF.md
# Bayer Color Steering Gain Selector

This block decides, pixel by pixel, which of four programmable gain codes applies to the sample currently coming off a Bayer-mosaic image sensor. Vertical and horizontal sync pulses and a pixel-valid strobe, all sampled on the pixel clock, drive it. It tracks three things: where the current pixel sits in its 2x2 colour cell, which line pair the current row belongs to, and which field of an interlaced frame is active. It then issues the selected 6-bit code together with a 2-bit channel index. A downstream programmable amplifier consumes the code.

Two steering modes exist. In mosaic-separate mode every frame starts with the GAIN0/GAIN1 row pair and alternates row pairs line by line. In VD-selected mode, meant for interlaced sensors, a field flag flips at every vertical sync, and odd fields start on the GAIN2/GAIN3 pair instead. The gain register inputs are shadowed and captured only at a vertical sync, so a frame never sees a gain change part way through.

Top module: `bayer_gain_steer`

## Requirements
- R1: While reset is asserted and after it, until the first valid pixel, `out_valid`, `gain_code` and `chan_idx` are all zero.
- R2: Each pixel presented with `pix_valid` high produces `out_valid` high on the next clock. A clock without `pix_valid` produces `out_valid` low on the next clock, and `gain_code` and `chan_idx` keep their previous values.
- R3: `chan_idx` is {row-pair bit, pixel bit}, where value k means GAIN k (0..3). `gain_code` equals the captured GAINk value for that index.
- R4: The pixel bit is 0 on the first valid pixel of a line and toggles on every following valid pixel. Clocks without `pix_valid` do not advance it. A pixel arriving in the same clock as `hd` or `vd` is the first pixel of its line.
- R5: The first `hd` after a `vd` begins line 0 of the field, and each later `hd` toggles the line parity. The row-pair bit is the line parity, further inverted by the field flag in VD-selected mode.
- R6: In mosaic-separate mode (`mode_vd_sel`=0), every field starts with the GAIN0/GAIN1 pair on line 0, whatever the field flag holds.
- R7: In VD-selected mode (`mode_vd_sel`=1), the field flag toggles on every `vd`. The first `vd` after reset begins an even field, and line 0 uses GAIN0/GAIN1 in even fields and GAIN2/GAIN3 in odd fields.
- R8: `gain_cfg0`..`gain_cfg3` are captured only in a clock where `vd` is high. Changes at any other time have no effect on `gain_code` until the next `vd`. A pixel coincident with `vd` already uses the newly captured values.
- R9: Gain codes are 6-bit two's-complement values passed through unaltered, including the extremes 6'b100000 (minimum) and 6'b011111 (maximum).
- R10: `vd` and `hd` high in the same clock begin line 0 of the new field at once, so a pixel in that clock in mosaic-separate mode gets channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_vd_sel | input | 1 | 0 = mosaic-separate steering, 1 = VD-selected steering |
| vd | input | 1 | Vertical sync pulse, one clock wide |
| hd | input | 1 | Horizontal sync pulse, one clock wide |
| pix_valid | input | 1 | A pixel is present this clock |
| gain_cfg0 | input | 6 | Gain code for channel 0 |
| gain_cfg1 | input | 6 | Gain code for channel 1 |
| gain_cfg2 | input | 6 | Gain code for channel 2 |
| gain_cfg3 | input | 6 | Gain code for channel 3 |
| gain_code | output | 6 | Selected gain code for the last valid pixel |
| chan_idx | output | 2 | Channel index of the last valid pixel |
| out_valid | output | 1 | `gain_code`/`chan_idx` were updated by the previous clock |

## Verification
Sync pulses and captured gains act within the same clock in which they are sampled. Each result is therefore due exactly one clock after the pixel it belongs to, with nothing pending deeper in the pipeline. The bench drives its inputs just after a falling edge. Its reference model updates at the rising edge from those same inputs, and it compares all three outputs at the next falling edge. Because of this, every comparison falls one register stage after its stimulus. Coincident pulses (a pixel with `hd`, with `vd`, or with both) and gain changes between vertical syncs are placed at exact cycles. The model predicts them from line, pixel and field counters of its own.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
    localparam int CH_NUM = 4;
    localparam int CH_W   = $clog2(CH_NUM);

    typedef struct packed {
        logic field_odd;
        logic line_par;
        logic pix_par;
    } phase_t;
endpackage

// File: rtl/bgs_phase_track.sv
module bgs_phase_track
    import bgs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_vd_sel,
    input  logic            vd,
    input  logic            hd,
    input  logic            pix_valid,
    output logic [CH_W-1:0] chan_sel
);
    phase_t cur_d, cur_q, eff;

    always_comb begin
        // sync pulses take effect in the clock they are sampled
        eff.field_odd = vd ? ~cur_q.field_odd : cur_q.field_odd;
        if (vd)
            eff.line_par = ~hd;
        else if (hd)
            eff.line_par = ~cur_q.line_par;
        else
            eff.line_par = cur_q.line_par;
        eff.pix_par = (vd || hd) ? 1'b0 : cur_q.pix_par;

        chan_sel = {eff.line_par ^ (mode_vd_sel & eff.field_odd), eff.pix_par};

        cur_d         = eff;
        cur_d.pix_par = eff.pix_par ^ pix_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.field_odd <= 1'b1;
            cur_q.line_par  <= 1'b1;
            cur_q.pix_par   <= 1'b0;
        end else begin
            cur_q <= cur_d;
        end
    end
endmodule

// File: rtl/bgs_shadow_bank.sv
module bgs_shadow_bank
    import bgs_pkg::*;
#(
    parameter int GAIN_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [CH_NUM-1:0][GAIN_W-1:0] cfg,
    output logic [CH_NUM-1:0][GAIN_W-1:0] gain_eff
);
    for (genvar g = 0; g < CH_NUM; g++) begin : g_lane
        logic [GAIN_W-1:0] lane_d, lane_q;

        always_comb begin
            lane_d      = load ? cfg[g] : lane_q;
            gain_eff[g] = lane_d;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) lane_q <= '0;
            else        lane_q <= lane_d;
        end
    end
endmodule

// File: rtl/bgs_out_stage.sv
module bgs_out_stage
    import bgs_pkg::*;
#(
    parameter int GAIN_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pix_valid,
    input  logic [CH_W-1:0]               chan_sel,
    input  logic [CH_NUM-1:0][GAIN_W-1:0] gain_eff,
    output logic [GAIN_W-1:0]             gain_code,
    output logic [CH_W-1:0]               chan_idx,
    output logic                          out_valid
);
    typedef struct packed {
        logic              vld;
        logic [CH_W-1:0]   chan;
        logic [GAIN_W-1:0] code;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = pix_valid;
        if (pix_valid) begin
            out_d.chan = chan_sel;
            out_d.code = gain_eff[chan_sel];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign gain_code = out_q.code;
    assign chan_idx  = out_q.chan;
    assign out_valid = out_q.vld;
endmodule

// File: rtl/bayer_gain_steer.sv
module bayer_gain_steer
    import bgs_pkg::*;
#(
    parameter int GAIN_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_vd_sel,
    input  logic              vd,
    input  logic              hd,
    input  logic              pix_valid,
    input  logic [GAIN_W-1:0] gain_cfg0,
    input  logic [GAIN_W-1:0] gain_cfg1,
    input  logic [GAIN_W-1:0] gain_cfg2,
    input  logic [GAIN_W-1:0] gain_cfg3,
    output logic [GAIN_W-1:0] gain_code,
    output logic [1:0]        chan_idx,
    output logic              out_valid
);
    logic [CH_NUM-1:0][GAIN_W-1:0] cfg_arr, gain_eff;
    logic [CH_W-1:0]               chan_sel;

    assign cfg_arr = {gain_cfg3, gain_cfg2, gain_cfg1, gain_cfg0};

    bgs_phase_track u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_vd_sel (mode_vd_sel),
        .vd          (vd),
        .hd          (hd),
        .pix_valid   (pix_valid),
        .chan_sel    (chan_sel)
    );

    bgs_shadow_bank #(.GAIN_W(GAIN_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (vd),
        .cfg      (cfg_arr),
        .gain_eff (gain_eff)
    );

    bgs_out_stage #(.GAIN_W(GAIN_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .chan_sel  (chan_sel),
        .gain_eff  (gain_eff),
        .gain_code (gain_code),
        .chan_idx  (chan_idx),
        .out_valid (out_valid)
    );
endmodule

// File: rtl/bgs_checker.sv
module bgs_checker #(
    parameter int GAIN_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_vd_sel,
    input logic              vd,
    input logic              hd,
    input logic              pix_valid,
    input logic [GAIN_W-1:0] gain_code,
    input logic [1:0]        chan_idx,
    input logic              out_valid
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid); // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> ($stable(gain_code) && $stable(chan_idx))); // R2
    AST_SYNC_FIRST_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && (hd || vd)) |=> (chan_idx[0] == 1'b0)); // R4
    AST_PIXEL_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid ##1 (pix_valid && !hd && !vd)) |=> (chan_idx[0] != $past(chan_idx[0]))); // R4
    AST_FIELD_START_CH0: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && vd && hd && !mode_vd_sel) |=> (chan_idx == 2'd0)); // R10
endmodule

bind bayer_gain_steer bgs_checker #(.GAIN_W(GAIN_W)) u_bgs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_vd_sel (mode_vd_sel),
    .vd          (vd),
    .hd          (hd),
    .pix_valid   (pix_valid),
    .gain_code   (gain_code),
    .chan_idx    (chan_idx),
    .out_valid   (out_valid)
);

// File: tb/bayer_gain_steer_test.sv
module bayer_gain_steer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_vd_sel = 1'b0, vd = 1'b0, hd = 1'b0, pix_valid = 1'b0;
    logic [5:0] gain_cfg0 = '0, gain_cfg1 = '0, gain_cfg2 = '0, gain_cfg3 = '0;
    logic [5:0] gain_code;
    logic [1:0] chan_idx;
    logic       out_valid;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int  line_num = -1, pix_cnt = 0;
    bit  field_odd = 1'b1;
    int  shadow [4] = '{0, 0, 0, 0};
    int  exp_code = 0, exp_chan = 0;
    bit  exp_valid = 1'b0;

    always #4 clk = ~clk;

    bayer_gain_steer uut (
        .clk(clk), .rst_n(rst_n), .mode_vd_sel(mode_vd_sel), .vd(vd), .hd(hd),
        .pix_valid(pix_valid), .gain_cfg0(gain_cfg0), .gain_cfg1(gain_cfg1),
        .gain_cfg2(gain_cfg2), .gain_cfg3(gain_cfg3),
        .gain_code(gain_code), .chan_idx(chan_idx), .out_valid(out_valid)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            line_num = -1; pix_cnt = 0; field_odd = 1'b1;
            shadow = '{0, 0, 0, 0};
            exp_code = 0; exp_chan = 0; exp_valid = 1'b0;
        end else begin
            if (vd) begin
                shadow[0] = gain_cfg0; shadow[1] = gain_cfg1;
                shadow[2] = gain_cfg2; shadow[3] = gain_cfg3;
                field_odd = !field_odd;
                line_num  = hd ? 0 : -1;
                pix_cnt   = 0;
            end else if (hd) begin
                line_num++;
                pix_cnt = 0;
            end
            exp_valid = pix_valid;
            if (pix_valid) begin
                int row;
                row = (line_num + ((mode_vd_sel && field_odd) ? 1 : 0)) & 1;
                exp_chan = row * 2 + (pix_cnt & 1);
                exp_code = shadow[exp_chan];
                pix_cnt++;
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare at the falling edge, then drive the next inputs
    task automatic step(bit v, bit h, bit p);
        @(negedge clk);
        check("R2", "out_valid", out_valid, exp_valid);
        check(exp_valid ? cur_req : "R2", "chan_idx", chan_idx, exp_chan);
        check(exp_valid ? cur_req : "R2", "gain_code", gain_code, exp_code);
        vd = v; hd = h; pix_valid = p;
    endtask

    task automatic run_line(int n, bit gaps);
        step(1'b0, 1'b1, 1'b1);
        for (int i = 1; i < n; i++) begin
            if (gaps && (i % 3 == 0)) step(1'b0, 1'b0, 1'b0);
            step(1'b0, 1'b0, 1'b1);
        end
        step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic run_field(int lines, bit gaps);
        step(1'b1, 1'b0, 1'b0);
        for (int l = 0; l < lines; l++) run_line(5, gaps);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check("R1", "out_valid", out_valid, 0);
        check("R1", "gain_code", gain_code, 0);
        check("R1", "chan_idx", chan_idx, 0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0);
        check("R1", "out_valid idle", out_valid, 0);

        cur_req = "R3";
        gain_cfg0 = 6'd5; gain_cfg1 = 6'd10; gain_cfg2 = 6'd61; gain_cfg3 = 6'd20;
        run_field(3, 1'b0);

        cur_req = "R8";
        gain_cfg0 = 6'd1; gain_cfg1 = 6'd2; gain_cfg2 = 6'd3; gain_cfg3 = 6'd4;
        run_line(4, 1'b0);
        run_line(4, 1'b0);
        step(1'b1, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        run_line(4, 1'b0);

        cur_req = "R4";
        run_line(7, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b1);

        cur_req = "R5";
        run_field(4, 1'b1);

        cur_req = "R6";
        mode_vd_sel = 1'b0;
        run_field(2, 1'b0);
        run_field(2, 1'b0);

        cur_req = "R7";
        mode_vd_sel = 1'b1;
        run_field(3, 1'b0);
        run_field(3, 1'b1);
        run_field(2, 1'b0);

        cur_req = "R10";
        mode_vd_sel = 1'b0;
        step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        mode_vd_sel = 1'b1;
        step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b1);

        cur_req = "R9";
        mode_vd_sel = 1'b0;
        gain_cfg0 = 6'b100000; gain_cfg1 = 6'b011111; gain_cfg2 = 6'b111111; gain_cfg3 = 6'b000000;
        run_field(2, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule